// File: doc/BRIEF.md
# Exposure and Frame Readout Sequencer

This block is the digital timing core of a square image sensor array. A start pulse, sampled on the system clock while the block is idle, opens an exposure interval. The length of that interval comes from two 8-bit exposure values whose step sizes are far apart: a fine value counting in small steps and a coarse value counting in steps 256 times larger. At the default settings the steps are 8 clocks and 2048 clocks. Both values are captured at the moment the exposure begins. Writes made to them later take effect only for the following frame.

When the exposure ends, the block raises a read window. During that window it walks every pixel coordinate of the array in raster order, one per clock, and drives an x/y address with a pixel-valid strobe to the pixel pipeline. The cycle after the last pixel, the window closes and a one-cycle frame-done pulse is raised. A fixed number of clocks after the window closes, the block launches the next exposure by itself. It keeps doing this until reset is asserted. The analog sampling path is outside this block.

Top module: `frame_sequencer`

## Requirements
- R1: While reset is held and after it is released, read_o, pix_valid_o and frame_done_o are 0 and pix_x_o and pix_y_o are 0. The block stays idle until start_i is sampled high.
- R2: If start_i is high at a rising clock edge while the block is idle, that edge launches an exposure of E = fine×C0_STEP + coarse×C1_STEP clocks. read_o is first high after the edge that is E+1 edges later.
- R3: When both exposure values are zero (E = 0), read_o rises on the edge right after the launch edge. The frame is then read with the same window length and pixel order as any other frame.
- R4: For COLS×ROWS consecutive cycles, read_o and pix_valid_o are high. The coordinates start at (0,0) and step one pixel per clock with x changing fastest, ending at (COLS-1, ROWS-1).
- R5: frame_done_o is high for exactly one cycle: the first cycle after the last pixel, which is also the cycle in which read_o has just fallen.
- R6: The next exposure is launched internally on the edge RESTART_GAP clocks after the edge on which read_o fell. read_o therefore rises again RESTART_GAP + E' + 1 edges after that fall, where E' comes from the exposure values present at the relaunch edge.
- R7: The exposure values are captured only at a launch edge. Changing them during an exposure or a read window does not change the current frame's timing.
- R8: start_i has no effect unless the block is idle. Pulsing it during an exposure or a read neither restarts nor shortens the frame.
- R9: Frames repeat without further stimulus until reset. Asserting reset mid-frame ends the read window at once and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sensing start request, sampled while idle |
| exp_fine_i | input | 8 | Fine exposure count (C0_STEP clocks per unit) |
| exp_coarse_i | input | 8 | Coarse exposure count (C1_STEP clocks per unit) |
| read_o | output | 1 | High during the pixel read window |
| pix_valid_o | output | 1 | Pixel strobe, one pixel per cycle while reading |
| pix_x_o | output | $clog2(COLS) | Column address of the current pixel |
| pix_y_o | output | $clog2(ROWS) | Row address of the current pixel |
| frame_done_o | output | 1 | One-cycle pulse after the last pixel of a frame |

## Verification
The bench compares every output on every clock against a behavioural model, and it also measures edge distances between the launch, the rise and fall of read_o, and the done pulse. The corner cases are the following:
- A zero exposure. An off-by-one here would skip the exposure state or add a spare cycle, so the rise would land one edge early or late.
- Exposure values rewritten in the middle of a frame. A design that reads them live instead of capturing them would stretch or shrink the running exposure.
- start_i pulsed during an exposure. A design that honours it outside idle would restart the frame.
- Reset in the middle of a read. A design that misses it would keep the window open.

Miscounting the restart gap shows up directly as a wrong fall-to-rise distance.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_EXPOSE = 2'd1,
    SEQ_READ   = 2'd2,
    SEQ_GAP    = 2'd3
  } seq_state_e;

  // Exposure length in clocks: fine units plus coarse units.
  function automatic logic [31:0] exp_cycles(input logic [7:0] fine,
                                             input logic [7:0] coarse,
                                             input int unsigned fine_step,
                                             input int unsigned coarse_step);
    return 32'(fine) * 32'(fine_step) + 32'(coarse) * 32'(coarse_step);
  endfunction

endpackage

// File: rtl/seq_down_counter.sv
module seq_down_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_raster_scan.sv
module seq_raster_scan #(
  parameter int unsigned COLS = 128,
  parameter int unsigned ROWS = 128,
  localparam int unsigned XW = $clog2(COLS),
  localparam int unsigned YW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          last
);
  localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
  localparam logic [YW-1:0] YMAX = YW'(ROWS - 1);

  logic x_end;
  assign x_end = (x == XMAX);
  assign last  = x_end && (y == YMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (advance) begin
      x <= x_end ? '0 : x + 1'b1;
      if (x_end) y <= (y == YMAX) ? '0 : y + 1'b1;
    end
  end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int unsigned COLS        = 128,
  parameter int unsigned ROWS        = 128,
  parameter int unsigned C0_STEP     = 8,
  parameter int unsigned C1_STEP     = 2048,
  parameter int unsigned RESTART_GAP = 5,
  localparam int unsigned XW = $clog2(COLS),
  localparam int unsigned YW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    exp_fine_i,
  input  logic [7:0]    exp_coarse_i,
  output logic          read_o,
  output logic          pix_valid_o,
  output logic [XW-1:0] pix_x_o,
  output logic [YW-1:0] pix_y_o,
  output logic          frame_done_o
);
  import seq_pkg::*;

  localparam int unsigned MAX_EXP = 255 * C0_STEP + 255 * C1_STEP;
  localparam int unsigned EXP_W   = $clog2(MAX_EXP + 1);
  localparam int unsigned GAP_W   = $clog2(RESTART_GAP + 1);
  localparam logic [XW-1:0] XMAX  = XW'(COLS - 1);

  seq_state_e   state_q, state_d;
  logic         launch, exp_zero, gap_zero, scan_last, scan_adv, gap_load;
  logic         done_q;
  logic [31:0]  exp_full;
  logic [EXP_W-1:0] exp_load_val;

  // Named internal events
  assign launch   = ((state_q == SEQ_IDLE) && start_i) ||
                    ((state_q == SEQ_GAP) && gap_zero);
  assign scan_adv = (state_q == SEQ_READ);
  assign gap_load = scan_adv && scan_last;

  assign exp_full     = exp_cycles(exp_fine_i, exp_coarse_i, C0_STEP, C1_STEP);
  assign exp_load_val = exp_full[EXP_W-1:0];

  seq_down_counter #(.W(EXP_W)) u_exp_timer (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .load_val(exp_load_val), .zero(exp_zero)
  );

  seq_down_counter #(.W(GAP_W)) u_gap_timer (
    .clk(clk), .rst_n(rst_n), .load(gap_load),
    .load_val(GAP_W'(RESTART_GAP - 1)), .zero(gap_zero)
  );

  seq_raster_scan #(.COLS(COLS), .ROWS(ROWS)) u_scan (
    .clk(clk), .rst_n(rst_n), .advance(scan_adv),
    .x(pix_x_o), .y(pix_y_o), .last(scan_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (launch)    state_d = SEQ_EXPOSE;
      SEQ_EXPOSE: if (exp_zero)  state_d = SEQ_READ;
      SEQ_READ:   if (scan_last) state_d = SEQ_GAP;
      SEQ_GAP:    if (launch)    state_d = SEQ_EXPOSE;
      default:                   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= gap_load;
    end
  end

  assign read_o       = (state_q == SEQ_READ);
  assign pix_valid_o  = scan_adv;
  assign frame_done_o = done_q;

  // Assertions
  a_r3_zero_exp_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_EXPOSE && exp_zero) |=> read_o);

  a_r4_origin_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_o) |-> (pix_x_o == '0 && pix_y_o == '0));

  a_r4_x_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (read_o && $past(read_o)) |->
      (pix_x_o == (($past(pix_x_o) == XMAX) ? '0 : $past(pix_x_o) + 1'b1)));

  a_r5_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> $fell(read_o));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  a_r8_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (read_o && !scan_last) |=> read_o);
endmodule

// File: tb/sim_frame_sequencer.sv
module sim_frame_sequencer;
  localparam int COLS = 4, ROWS = 3, C0S = 2, C1S = 16, GAP = 5;
  localparam int NPIX = COLS * ROWS;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [7:0] exp_fine_i = 8'd3, exp_coarse_i = 8'd1;
  logic read_o, pix_valid_o, frame_done_o;
  logic [1:0] pix_x_o, pix_y_o;

  frame_sequencer #(.COLS(COLS), .ROWS(ROWS), .C0_STEP(C0S), .C1_STEP(C1S),
                    .RESTART_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .exp_fine_i(exp_fine_i),
    .exp_coarse_i(exp_coarse_i), .read_o(read_o), .pix_valid_o(pix_valid_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .frame_done_o(frame_done_o));

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0, cmp_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 exposing, 2 reading, 3 waiting
  int ph = 0, left = 0, pix = 0, m_done = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      ph = 0; left = 0; pix = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (ph == 0) begin
        if (start_i) begin left = exp_fine_i * C0S + exp_coarse_i * C1S; ph = 1; end
      end else if (ph == 1) begin
        if (left == 0) begin ph = 2; pix = 0; end else left--;
      end else if (ph == 2) begin
        if (pix == NPIX - 1) begin ph = 3; pix = 0; left = GAP - 1; m_done = 1; end
        else pix++;
      end else begin
        if (left == 0) begin left = exp_fine_i * C0S + exp_coarse_i * C1S; ph = 1; end
        else left--;
      end
    end
  end

  // Per-cycle comparison and edge bookkeeping
  int rise_at[16], fall_at[16], done_at[16];
  int rise_n = 0, fall_n = 0, done_n = 0;
  logic prev_read = 0;
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      chk(read_o == (ph == 2), "R4 read_o vs model", read_o, ph == 2);
      chk(pix_valid_o == (ph == 2), "R4 pix_valid_o vs model", pix_valid_o, ph == 2);
      chk(pix_x_o == pix % COLS, "R4 pix_x_o vs model", pix_x_o, pix % COLS);
      chk(pix_y_o == pix / COLS, "R4 pix_y_o vs model", pix_y_o, pix / COLS);
      chk(frame_done_o == m_done, "R5 frame_done_o vs model", frame_done_o, m_done);
    end
    if (read_o && !prev_read && rise_n < 16) begin rise_at[rise_n] = cyc; rise_n++; end
    if (!read_o && prev_read && fall_n < 16) begin fall_at[fall_n] = cyc; fall_n++; end
    if (frame_done_o && done_n < 16) begin done_at[done_n] = cyc; done_n++; end
    prev_read = read_o;
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  int s_edge;
  initial begin
    repeat (3) @(negedge clk);
    chk(read_o == 0 && frame_done_o == 0, "R1 outputs low in reset", read_o, 0);
    rst_n = 1; cmp_on = 1;
    @(posedge clk); #2;
    chk(pix_x_o == 0 && pix_y_o == 0, "R1 coordinates zero", pix_x_o, 0);
    repeat (10) @(negedge clk);
    chk(rise_n == 0, "R1 idle without start", rise_n, 0);

    // Launch with E = 3*2 + 1*16 = 22, then rewrite values mid-exposure
    @(negedge clk) start_i = 1;
    @(posedge clk); #2; s_edge = cyc;
    @(negedge clk) start_i = 0; exp_fine_i = 0; exp_coarse_i = 0;
    wait (rise_n == 1);
    chk(rise_at[0] - s_edge == 23, "R2 R7 launch-to-read distance", rise_at[0] - s_edge, 23);
    repeat (3) @(negedge clk);
    start_i = 1; @(negedge clk) start_i = 0;   // ignored during read
    wait (fall_n == 1);
    chk(fall_at[0] - rise_at[0] == NPIX, "R4 R8 window length", fall_at[0] - rise_at[0], NPIX);
    wait (done_n == 1);
    chk(done_at[0] == fall_at[0], "R5 done at fall", done_at[0], fall_at[0]);

    // Second frame: zero exposure, relaunched internally
    wait (rise_n == 2);
    chk(rise_at[1] - fall_at[0] == GAP + 1, "R3 R6 restart with zero exposure",
        rise_at[1] - fall_at[0], GAP + 1);
    @(negedge clk) exp_fine_i = 5;
    wait (fall_n == 2);
    chk(fall_at[1] - rise_at[1] == NPIX, "R3 zero exposure full window",
        fall_at[1] - rise_at[1], NPIX);
    repeat (8) @(negedge clk);
    start_i = 1; @(negedge clk) start_i = 0;   // ignored during exposure
    wait (rise_n == 3);
    chk(rise_at[2] - fall_at[1] == GAP + 11, "R6 R7 R8 third frame timing",
        rise_at[2] - fall_at[1], GAP + 11);
    chk(done_n == 2, "R9 frames keep repeating", done_n, 2);

    // Reset in the middle of a read
    repeat (3) @(negedge clk);
    rst_n = 0;
    #1 chk(read_o == 0, "R9 reset ends read window", read_o, 0);
    @(negedge clk) rst_n = 1;
    repeat (20) @(negedge clk);
    chk(rise_n == 3 && read_o == 0, "R9 idle after reset", rise_n, 3);
    summary();
  end
endmodule